// File: doc/BRIEF.md
# Processor Power Mode Controller

This block decides which power state a processor core is in: full power, doze, nap or sleep. Software asks for a low-power state by setting exactly one of three mode-select bits together with a power-enable bit. Doze is entered straight away. Nap and sleep first go through a waiting state. In that state the block raises a quiesce request and holds until the system returns a quiesce acknowledge while the bus unit is idle.

While in a low-power state, the block watches eight wake-up event lines and returns to full power when one of them fires. Sleep does not treat the decrementer line as a wake source. In nap, if the acknowledge stays negated for a fixed number of consecutive clocks, the block moves to doze so that snooping runs again.

The block drives three clock-domain enables (snoop logic, decrementer, data cache) directly from its state. It also gives a one-cycle pulse whenever the core comes back to full power from a low-power state. All pins are plain control and status levels. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After asynchronous reset (rst_n low), state is FULL (code 0), all three enables are 1, qreq is 0 and wake_pulse is 0. State codes are: FULL=0, DOZE=1, NAP=2, SLEEP=3, WAIT (handshake pending)=4.
- R2: A low-power request is taken in FULL only when all of these hold: pwr_en is 1, exactly one bit of mode_sel is set (bit0 doze, bit1 nap, bit2 sleep), and no wake_ev bit is set. With zero bits or more than one bit set, state stays FULL.
- R3: A taken doze request moves FULL to DOZE at the same clock edge. In DOZE, snoop_en, dcache_en and dec_en are all 1.
- R4: A taken nap or sleep request moves FULL to WAIT, where qreq is 1 and all enables stay 1. WAIT moves to the requested state only at an edge where qack and bus_idle are both 1.
- R5: Any wake_ev bit set while in WAIT returns the block to FULL at that edge, and wake_pulse stays 0.
- R6: DOZE and NAP return to FULL at any edge where any wake_ev bit is set. The bits are: 0 external interrupt, 1 system management interrupt, 2 hard reset, 3 soft reset, 4 decrementer, 5 performance monitor, 6 thermal, 7 machine check.
- R7: SLEEP returns to FULL on any wake_ev bit except bit 4. The decrementer bit on its own leaves the block in SLEEP.
- R8: In NAP, qack sampled low at NEG_CYC (default 4) consecutive edges moves the block to DOZE at the last of those edges. A high qack restarts the count.
- R9: In NAP, snoop_en=0, dcache_en=0 and dec_en=1. In SLEEP, all three enables are 0. qreq is 1 in WAIT, NAP and SLEEP, and 0 in FULL and DOZE.
- R10: wake_pulse is 1 for exactly the first cycle in FULL after leaving DOZE, NAP or SLEEP, and 0 at all other times.
- R11: Hard reset (wake_ev bit 2) forces FULL at the next edge from every state. It also clears the qack-negation count, so a later nap needs a full NEG_CYC run of low qack again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode-select bits: bit0 doze, bit1 nap, bit2 sleep |
| pwr_en | input | 1 | Power-saving enable |
| bus_idle | input | 1 | Bus unit idle flag |
| qack | input | 1 | Quiesce acknowledge from the system |
| wake_ev | input | 8 | Wake-up event lines (bit map in R6) |
| state | output | 3 | Current state code |
| snoop_en | output | 1 | Snoop logic clock enable |
| dec_en | output | 1 | Decrementer clock enable |
| dcache_en | output | 1 | Data cache clock enable |
| qreq | output | 1 | Quiesce request |
| wake_pulse | output | 1 | One-cycle return-to-full-power pulse |

## Verification
Directed sequences cover the following cases:
- zero-bit and multi-bit mode words, which show that legal one-hot requests are told apart from illegal ones;
- handshakes where qack or bus_idle is withheld, which separate WAIT from early entry;
- a nap where qack runs of three low cycles are broken by a high cycle before a run of four, which separates counting consecutive cycles from counting total cycles;
- a decrementer-only event in sleep against the same event in nap, which shows that the wake mask depends on state.

A seeded random phase then mixes mode words, enables, acknowledges and sparse single-bit wake events. Every cycle is compared against a bench model of the state, the enables, qreq and the pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int NUM_MODE  = 3;
  localparam int NUM_WAKE  = 8;
  localparam int DEC_BIT   = 4;
  localparam int HRST_BIT  = 2;
  localparam int ST_W      = 3;

  typedef enum logic [ST_W-1:0] {
    PS_FULL  = 3'd0,
    PS_DOZE  = 3'd1,
    PS_NAP   = 3'd2,
    PS_SLEEP = 3'd3,
    PS_WAIT  = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic [NUM_MODE-1:0] mode_sel,
  input  logic                pwr_en,
  output logic                req_ok,
  output logic                sel_doze,
  output logic                sel_sleep
);
  logic [$clog2(NUM_MODE+1)-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_MODE; i++) begin
      ones = ones + {{($clog2(NUM_MODE+1)-1){1'b0}}, mode_sel[i]};
    end
  end

  assign req_ok    = pwr_en && (ones == 1);
  assign sel_doze  = mode_sel[0];
  assign sel_sleep = mode_sel[2];
endmodule

// File: rtl/pwr_wake_mask.sv
module pwr_wake_mask
  import pwr_mode_pkg::*;
(
  input  logic [NUM_WAKE-1:0] wake_ev,
  input  logic                in_sleep,
  output logic                wake_any,
  output logic                hard_rst
);
  logic [NUM_WAKE-1:0] mask;

  generate
    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_mask
      if (g == DEC_BIT) begin : g_dec
        assign mask[g] = !in_sleep;
      end else begin : g_other
        assign mask[g] = 1'b1;
      end
    end
  endgenerate

  assign wake_any = |(wake_ev & mask);
  assign hard_rst = wake_ev[HRST_BIT];
endmodule

// File: rtl/pwr_qack_timer.sv
module pwr_qack_timer #(
  parameter int NEG_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_nap,
  input  logic qack,
  output logic expire
);
  localparam int CW = $clog2(NEG_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(NEG_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire = in_nap && !qack && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!in_nap || qack || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R8
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_nap |=> cnt_q == '0);  // R11
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NEG_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MODE-1:0] mode_sel,
  input  logic                pwr_en,
  input  logic                bus_idle,
  input  logic                qack,
  input  logic [NUM_WAKE-1:0] wake_ev,
  output logic [ST_W-1:0]     state,
  output logic                snoop_en,
  output logic                dec_en,
  output logic                dcache_en,
  output logic                qreq,
  output logic                wake_pulse
);
  pwr_state_e st_q, st_nxt, tgt_q, tgt_nxt;
  logic req_ok, sel_doze, sel_sleep;
  logic wake_any, hard_rst, expire;
  logic pulse_q;

  pwr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .pwr_en   (pwr_en),
    .req_ok   (req_ok),
    .sel_doze (sel_doze),
    .sel_sleep(sel_sleep)
  );

  pwr_wake_mask u_wake (
    .wake_ev (wake_ev),
    .in_sleep(st_q == PS_SLEEP),
    .wake_any(wake_any),
    .hard_rst(hard_rst)
  );

  pwr_qack_timer #(.NEG_CYC(NEG_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .in_nap(st_q == PS_NAP),
    .qack  (qack),
    .expire(expire)
  );

  always_comb begin
    st_nxt  = st_q;
    tgt_nxt = tgt_q;
    case (st_q)
      PS_FULL: begin
        if (req_ok && !wake_any) begin
          if (sel_doze) begin
            st_nxt = PS_DOZE;
          end else begin
            st_nxt  = PS_WAIT;
            tgt_nxt = sel_sleep ? PS_SLEEP : PS_NAP;
          end
        end
      end
      PS_WAIT: begin
        if (wake_any)             st_nxt = PS_FULL;
        else if (qack && bus_idle) st_nxt = tgt_q;
      end
      PS_DOZE:  if (wake_any) st_nxt = PS_FULL;
      PS_NAP: begin
        if (wake_any)    st_nxt = PS_FULL;
        else if (expire) st_nxt = PS_DOZE;
      end
      PS_SLEEP: if (wake_any) st_nxt = PS_FULL;
      default:  st_nxt = PS_FULL;
    endcase
    if (hard_rst) st_nxt = PS_FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_FULL;
      tgt_q   <= PS_NAP;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      tgt_q   <= tgt_nxt;
      pulse_q <= (st_q == PS_DOZE || st_q == PS_NAP || st_q == PS_SLEEP)
                 && (st_nxt == PS_FULL);
    end
  end

  always_comb begin
    snoop_en  = 1'b1;
    dec_en    = 1'b1;
    dcache_en = 1'b1;
    qreq      = 1'b0;
    case (st_q)
      PS_WAIT:  qreq = 1'b1;
      PS_NAP: begin
        snoop_en  = 1'b0;
        dcache_en = 1'b0;
        qreq      = 1'b1;
      end
      PS_SLEEP: begin
        snoop_en  = 1'b0;
        dec_en    = 1'b0;
        dcache_en = 1'b0;
        qreq      = 1'b1;
      end
      default: ;
    endcase
  end

  assign state      = st_q;
  assign wake_pulse = pulse_q;

  AST_ENTRY_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_WAIT && !(qack && bus_idle)) |=> (st_q != PS_NAP && st_q != PS_SLEEP));  // R4
  AST_SLEEP_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP && (wake_ev & ~(NUM_WAKE'(1) << DEC_BIT)) == '0) |=> st_q == PS_SLEEP);  // R7
  AST_HRESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev[HRST_BIT] |=> st_q == PS_FULL);  // R11
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);  // R10
  AST_PULSE_IN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> st_q == PS_FULL);  // R10
  AST_ILLEGAL_MODE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FULL && $countones(mode_sel) != 1) |=> st_q == PS_FULL);  // R2
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int NEG = 4;
  localparam int FULL = 0, DOZE = 1, NAP = 2, SLEEP = 3, WAITS = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] mode_sel = 0;
  logic       pwr_en = 0, bus_idle = 0, qack = 0;
  logic [7:0] wake_ev = 0;
  logic [2:0] state;
  logic       snoop_en, dec_en, dcache_en, qreq, wake_pulse;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_st = FULL, m_tgt = NAP, m_cnt = 0;
  bit m_pulse = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NEG_CYC(NEG)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pwr_en(pwr_en),
    .bus_idle(bus_idle), .qack(qack), .wake_ev(wake_ev), .state(state),
    .snoop_en(snoop_en), .dec_en(dec_en), .dcache_en(dcache_en),
    .qreq(qreq), .wake_pulse(wake_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_en(input int st);
    case (st)
      NAP:     return 3'b010;
      SLEEP:   return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic bit one_hot3(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b010) || (m == 3'b100);
  endfunction

  task automatic tick();
    int nst = m_st, ntgt = m_tgt, ncnt = 0;
    bit wk;
    bit low_pwr;
    if (m_st == SLEEP) wk = |(wake_ev & 8'b1110_1111);
    else               wk = |wake_ev;
    case (m_st)
      FULL: if (pwr_en && one_hot3(mode_sel) && !wk) begin
        if (mode_sel[0]) nst = DOZE;
        else begin nst = WAITS; ntgt = mode_sel[2] ? SLEEP : NAP; end
      end
      WAITS: if (wk) nst = FULL; else if (qack && bus_idle) nst = m_tgt;
      DOZE:  if (wk) nst = FULL;
      NAP: begin
        if (wk) nst = FULL;
        else if (!qack && m_cnt == NEG - 1) nst = DOZE;
        else if (!qack) ncnt = m_cnt + 1;
      end
      SLEEP: if (wk) nst = FULL;
      default: nst = FULL;
    endcase
    if (wake_ev[2]) nst = FULL;
    if (nst != NAP || m_st != NAP) ncnt = 0;
    low_pwr = (m_st == DOZE || m_st == NAP || m_st == SLEEP);
    m_pulse = low_pwr && nst == FULL;
    m_st = nst; m_tgt = ntgt; m_cnt = ncnt;
    @(posedge clk); #1;
    chk("R6 state vs model", state, m_st);
    chk("R9 enables vs model", {snoop_en, dec_en, dcache_en}, exp_en(m_st));
    chk("R9 qreq vs model", qreq, (m_st == WAITS || m_st == NAP || m_st == SLEEP));
    chk("R10 wake_pulse vs model", wake_pulse, m_pulse);
  endtask

  task automatic drive(input logic [2:0] m, input bit en, input bit bi, input bit qa, input logic [7:0] w);
    mode_sel = m; pwr_en = en; bus_idle = bi; qack = qa; wake_ev = w;
  endtask

  task automatic enter_nap();
    drive(3'b010, 1, 0, 0, 0); tick();
    drive(3'b010, 1, 1, 1, 0); tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #5;
    chk("R1 reset state", state, FULL);
    chk("R1 reset enables", {snoop_en, dec_en, dcache_en}, 7);
    chk("R1 reset qreq", qreq, 0);
    chk("R1 reset pulse", wake_pulse, 0);
    @(negedge clk); rst_n = 1;

    drive(3'b011, 1, 1, 1, 0); tick(); chk("R2 two bits stay full", state, FULL);
    drive(3'b000, 1, 1, 1, 0); tick(); chk("R2 no bits stay full", state, FULL);
    drive(3'b001, 0, 1, 1, 0); tick(); chk("R2 pwr_en low stays full", state, FULL);
    drive(3'b001, 1, 1, 1, 8'h01); tick(); chk("R2 wake blocks entry", state, FULL);

    drive(3'b001, 1, 0, 0, 0); tick(); chk("R3 doze entry", state, DOZE);
    chk("R3 doze enables", {snoop_en, dec_en, dcache_en}, 7);
    drive(0, 0, 0, 0, 8'h10); tick(); chk("R6 dec wakes doze", state, FULL);
    chk("R10 pulse after doze", wake_pulse, 1);
    drive(0, 0, 0, 0, 0); tick(); chk("R10 pulse single", wake_pulse, 0);

    drive(3'b010, 1, 0, 1, 0); tick(); chk("R4 wait state", state, WAITS);
    chk("R4 qreq in wait", qreq, 1);
    drive(3'b010, 1, 0, 1, 0); tick(); chk("R4 bus busy holds", state, WAITS);
    drive(3'b010, 1, 1, 0, 0); tick(); chk("R4 no ack holds", state, WAITS);
    drive(3'b010, 1, 1, 1, 0); tick(); chk("R4 nap entry", state, NAP);
    chk("R9 nap enables", {snoop_en, dec_en, dcache_en}, 3'b010);

    for (int i = 0; i < 3; i++) begin drive(0, 0, 1, 0, 0); tick(); end
    chk("R8 three lows stay nap", state, NAP);
    drive(0, 0, 1, 1, 0); tick(); chk("R8 high restarts", state, NAP);
    for (int i = 0; i < 3; i++) begin drive(0, 0, 1, 0, 0); tick(); end
    chk("R8 three lows again", state, NAP);
    drive(0, 0, 1, 0, 0); tick(); chk("R8 fourth low to doze", state, DOZE);
    drive(0, 0, 0, 0, 8'h02); tick(); chk("R6 smi wakes doze", state, FULL);

    drive(3'b100, 1, 1, 0, 0); tick(); chk("R4 sleep wait", state, WAITS);
    drive(3'b100, 1, 1, 0, 8'h40); tick(); chk("R5 abort in wait", state, FULL);
    chk("R5 no pulse on abort", wake_pulse, 0);

    drive(3'b100, 1, 1, 1, 0); tick(); tick(); chk("R4 sleep entry", state, SLEEP);
    chk("R9 sleep enables", {snoop_en, dec_en, dcache_en}, 0);
    drive(0, 0, 1, 1, 8'h10); tick(); chk("R7 dec ignored in sleep", state, SLEEP);
    drive(0, 0, 1, 1, 8'h20); tick(); chk("R7 perf wakes sleep", state, FULL);
    chk("R10 pulse after sleep", wake_pulse, 1);

    enter_nap(); chk("R6 nap again", state, NAP);
    drive(0, 0, 1, 0, 8'h10); tick(); chk("R6 dec wakes nap", state, FULL);

    enter_nap();
    for (int i = 0; i < 3; i++) begin drive(0, 0, 1, 0, 0); tick(); end
    drive(0, 0, 1, 0, 8'h04); tick(); chk("R11 hreset from nap", state, FULL);
    enter_nap();
    for (int i = 0; i < 3; i++) begin drive(0, 0, 1, 0, 0); tick(); end
    chk("R11 count cleared", state, NAP);
    drive(0, 0, 1, 1, 8'h04); tick(); chk("R11 hreset forces full", state, FULL);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] w;
      w = ($urandom % 10 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      drive(3'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0,
            ($urandom % 2) != 0, w);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule